// File: doc/BRIEF.md
# Power Mode and Wake Sequencer

This block moves a chip through four phases: oscillator settling after power-on, a slow-clock phase, full-speed operation on the high-speed reference clock, and sleep. It runs entirely on the 32 kHz low-speed clock. The analog oscillator, the glitch-free clock multiplexers and the clock dividers are outside the block. The block drives them through enable outputs.

After reset release, the slow-clock enable stays low until a settling count has run out. Software then requests the switch to the reference clock. The reference enable rises, and a ready flag follows after a restart delay. Once ready, the derived-clock enable is on. Software puts the chip to sleep by writing a power-down bit. Sleep drops the reference enable and the derived-clock enable, and it starts a 16-bit wake timer. Sleep ends when the timer runs out or when any enabled one of four asynchronous wake lines goes high. On wake, the power-down bit clears itself and a sticky status word records the cause. The reference clock is then brought back through the same restart delay.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: From reset until exactly SETTLE_CYC (default 1024) rising clock edges after reset release, `slow_clk_en` is 0. From that edge on it is 1 and stays 1.
- R2: `ref_clk_en` rises only on a `ref_switch_req` pulse taken in the slow-clock phase. A `pde_set` pulse before full-speed operation is ignored. A `ref_switch_req` pulse during full-speed operation has no effect.
- R3: `ref_ready` and `clk_out_en` rise exactly RESTART_CYC (default 16) edges after the edge at which `ref_clk_en` rose. `ref_clk_en` stays high throughout that delay.
- R4: A `pde_set` pulse while `ref_ready` is 1 sets `pde` at the next edge. While `pde` is 1, `ref_clk_en`, `ref_ready` and `clk_out_en` are all 0.
- R5: The wake timer is loaded from `wake_tmr_load` at sleep entry. A nonzero load L ends sleep after exactly L cycles with `pde` high. A load of 0 disables timer wake.
- R6: A wake line i with `wake_mask[i]`=1 that goes high ends sleep 2 edges after the edge at which it is first sampled high, because it passes through two synchronizing flops. A line whose mask bit is 0 does not end sleep.
- R7: On wake, `pde` clears itself and `wake_cause` sets bit 0 for a timer wake and bit i+1 for each enabled wake line i that is active. If the timer and a line fire in the same cycle, both bits are set.
- R8: Bits of `wake_cause` are sticky across wakes. Each bit clears when a 1 is pulsed on the same bit of `cause_clr`, and the other bits are left unchanged.
- R9: At the wake edge, `ref_clk_en` returns to 1 and `ref_ready` stays 0 for RESTART_CYC edges, then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz low-speed clock |
| rst_n | input | 1 | Active-low power-on reset |
| ref_switch_req | input | 1 | Software pulse: move to the reference clock |
| pde_set | input | 1 | Software pulse: write 1 to the power-down bit |
| wake_tmr_load | input | 16 | Wake timer load value, 0 disables timer wake |
| wake_in | input | 4 | Asynchronous external wake lines, active high |
| wake_mask | input | 4 | Per-line wake enable |
| cause_clr | input | 5 | Write-1-to-clear pulses for `wake_cause` |
| slow_clk_en | output | 1 | Release of the low-speed clock to the system |
| ref_clk_en | output | 1 | Enable of the high-speed reference clock |
| ref_ready | output | 1 | Reference clock has had its restart delay |
| clk_out_en | output | 1 | Enable of the derived clock outputs |
| pde | output | 1 | Power-down bit, high during sleep |
| wake_cause | output | 5 | Sticky wake cause: bit 0 timer, bits 4:1 lines 3:0 |

## Verification
The bench checks the exact edges at which the settle count, the restart delay and the wake timer end. An off-by-one in any of these counters moves `slow_clk_en`, `ref_ready` or the fall of `pde` by one sampled cycle, so the bench detects it. It targets the timer and a line firing in the same cycle, where a design that prioritises one source would drop a cause bit. It also targets a timer load of 0, where a design that treats 0 as a full count would wake on its own. It covers a masked line and power-down or switch requests made in the wrong phase, where a design that ignores the mask or the phase would leave sleep or change clocks when it should not. Partial clearing of accumulated causes is also checked, which catches a status word that clears as a whole or loses old bits when a new wake arrives.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        PM_SETTLE  = 3'd0,
        PM_SLOW    = 3'd1,
        PM_RESTART = 3'd2,
        PM_RUN     = 3'd3,
        PM_SLEEP   = 3'd4
    } pm_state_e;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[gi];
                stab_q <= meta_q;
            end
        end

        assign sync_out[gi] = stab_q;
    end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             armed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && tmr_q.armed && (tmr_q.cnt == TMR_W'(1));
        if (load) begin
            tmr_d.cnt   = load_val;
            tmr_d.armed = |load_val;
        end else if (run && tmr_q.armed) begin
            if (tmr_q.cnt == TMR_W'(1)) begin
                tmr_d.armed = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int SETTLE_CYC  = 1024,
    parameter int RESTART_CYC = 16,
    parameter int WAKE_LINES  = 4,
    parameter int TMR_W       = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_switch_req,
    input  logic                  pde_set,
    input  logic [TMR_W-1:0]      wake_tmr_load,
    input  logic [WAKE_LINES-1:0] wake_in,
    input  logic [WAKE_LINES-1:0] wake_mask,
    input  logic [WAKE_LINES:0]   cause_clr,
    output logic                  slow_clk_en,
    output logic                  ref_clk_en,
    output logic                  ref_ready,
    output logic                  clk_out_en,
    output logic                  pde,
    output logic [WAKE_LINES:0]   wake_cause
);

    localparam int CNT_MAX = (SETTLE_CYC > RESTART_CYC) ? SETTLE_CYC : RESTART_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int CAUSE_W = WAKE_LINES + 1;

    typedef struct packed {
        pm_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [CAUSE_W-1:0] cause;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [WAKE_LINES-1:0] wake_sync;
    logic [WAKE_LINES-1:0] ext_hit;
    logic                  tmr_load;
    logic                  tmr_run;
    logic                  tmr_expire;
    logic [CAUSE_W-1:0]    new_cause;

    pwr_wake_sync #(
        .LINES (WAKE_LINES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_in),
        .sync_out (wake_sync)
    );

    assign tmr_run = (seq_q.state == PM_SLEEP);

    pwr_wake_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (wake_tmr_load),
        .run      (tmr_run),
        .expire   (tmr_expire)
    );

    assign ext_hit = wake_sync & wake_mask;

    always_comb begin
        seq_d     = seq_q;
        tmr_load  = 1'b0;
        new_cause = '0;
        unique case (seq_q.state)
            PM_SETTLE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = PM_SLOW;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PM_SLOW: begin
                if (ref_switch_req) begin
                    seq_d.state = PM_RESTART;
                    seq_d.cnt   = CNT_W'(RESTART_CYC - 1);
                end
            end
            PM_RESTART: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = PM_RUN;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PM_RUN: begin
                if (pde_set) begin
                    seq_d.state = PM_SLEEP;
                    tmr_load    = 1'b1;
                end
            end
            PM_SLEEP: begin
                if (tmr_expire || (|ext_hit)) begin
                    seq_d.state = PM_RESTART;
                    seq_d.cnt   = CNT_W'(RESTART_CYC - 1);
                    new_cause   = {ext_hit, tmr_expire};
                end
            end
            default: begin
                seq_d.state = PM_SETTLE;
                seq_d.cnt   = CNT_W'(SETTLE_CYC - 1);
            end
        endcase
        seq_d.cause = (seq_q.cause & ~cause_clr) | new_cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= PM_SETTLE;
            seq_q.cnt   <= CNT_W'(SETTLE_CYC - 1);
            seq_q.cause <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slow_clk_en = (seq_q.state != PM_SETTLE);
    assign ref_clk_en  = (seq_q.state == PM_RESTART) || (seq_q.state == PM_RUN);
    assign ref_ready   = (seq_q.state == PM_RUN);
    assign clk_out_en  = (seq_q.state == PM_RUN);
    assign pde         = (seq_q.state == PM_SLEEP);
    assign wake_cause  = seq_q.cause;

endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
    parameter int SETTLE_CYC = 1024,
    parameter int WAKE_LINES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pde_set,
    input logic                slow_clk_en,
    input logic                ref_clk_en,
    input logic                ref_ready,
    input logic                clk_out_en,
    input logic                pde,
    input logic [WAKE_LINES:0] wake_cause
);

    localparam int AGE_W = $clog2(SETTLE_CYC + 1) + 1;

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q < AGE_W'(SETTLE_CYC)) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        slow_clk_en |-> (age_q >= AGE_W'(SETTLE_CYC))); // R1

    AST_SLOW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slow_clk_en) |-> slow_clk_en); // R1

    AST_READY_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ready |-> ref_clk_en); // R3

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pde) |-> ($past(pde_set) && $past(ref_ready))); // R4

    AST_SLEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pde |-> (!ref_clk_en && !clk_out_en)); // R4

    AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pde) |-> (wake_cause != '0)); // R7

    AST_WAKE_REF_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pde) |-> (ref_clk_en && !ref_ready)); // R9

endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .WAKE_LINES (WAKE_LINES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pde_set     (pde_set),
    .slow_clk_en (slow_clk_en),
    .ref_clk_en  (ref_clk_en),
    .ref_ready   (ref_ready),
    .clk_out_en  (clk_out_en),
    .pde         (pde),
    .wake_cause  (wake_cause)
);

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;

    localparam int SETTLE  = 1024;
    localparam int RESTART = 16;

    typedef struct packed {
        logic [15:0] tmr;
        logic [15:0] dly;
        logic [1:0]  line;
        logic [3:0]  mask;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{tmr: 16'd5,  dly: 16'd100, line: 2'd0, mask: 4'b0001},
        '{tmr: 16'd0,  dly: 16'd3,   line: 2'd2, mask: 4'b0100},
        '{tmr: 16'd40, dly: 16'd10,  line: 2'd1, mask: 4'b0000},
        '{tmr: 16'd12, dly: 16'd10,  line: 2'd3, mask: 4'b1111},
        '{tmr: 16'd1,  dly: 16'd50,  line: 2'd0, mask: 4'b0001},
        '{tmr: 16'd0,  dly: 16'd1,   line: 2'd0, mask: 4'b1111},
        '{tmr: 16'd9,  dly: 16'd8,   line: 2'd3, mask: 4'b1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_switch_req = 1'b0;
    logic        pde_set = 1'b0;
    logic [15:0] wake_tmr_load = '0;
    logic [3:0]  wake_in = '0;
    logic [3:0]  wake_mask = '0;
    logic [4:0]  cause_clr = '0;
    logic        slow_clk_en;
    logic        ref_clk_en;
    logic        ref_ready;
    logic        clk_out_en;
    logic        pde;
    logic [4:0]  wake_cause;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pwr_wake_ctrl u_pwr_wake_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_switch_req (ref_switch_req),
        .pde_set        (pde_set),
        .wake_tmr_load  (wake_tmr_load),
        .wake_in        (wake_in),
        .wake_mask      (wake_mask),
        .cause_clr      (cause_clr),
        .slow_clk_en    (slow_clk_en),
        .ref_clk_en     (ref_clk_en),
        .ref_ready      (ref_ready),
        .clk_out_en     (clk_out_en),
        .pde            (pde),
        .wake_cause     (wake_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sleep from full-speed mode, drive a line at sleep cycle dly, measure sleep length,
    // then follow the restart delay back to ready.
    task automatic run_sleep(input logic [15:0] tmr, input logic [15:0] dly,
                             input logic [1:0] line, input logic [3:0] mask,
                             output int dur);
        dur = 0;
        wake_tmr_load = tmr;
        wake_mask     = mask;
        pde_set       = 1'b1;
        @(negedge clk);
        pde_set = 1'b0;
        chk("R4 pde set", 32'(pde), 32'd1);
        chk("R4 ref off", 32'({ref_clk_en, ref_ready, clk_out_en}), 32'd0);
        for (int n = 0; n < 3000; n++) begin
            if (n > 0) @(negedge clk);
            if (!pde) break;
            dur++;
            if (dur == int'(dly)) wake_in[line] = 1'b1;
        end
        wake_in = '0;
        chk("R9 ref back", 32'(ref_clk_en), 32'd1);
        chk("R9 not ready", 32'(ref_ready), 32'd0);
        repeat (RESTART - 1) @(negedge clk);
        chk("R9 ready late", 32'(ref_ready), 32'd0);
        @(negedge clk);
        chk("R9 ready", 32'(ref_ready), 32'd1);
    endtask

    task automatic clear_cause(input logic [4:0] bits);
        cause_clr = bits;
        @(negedge clk);
        cause_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int dur;
        int exp_dur;
        logic [4:0] exp_cause;

        repeat (3) @(negedge clk);
        chk("R1 reset slow", 32'(slow_clk_en), 32'd0);
        chk("R1 reset outs", 32'({ref_clk_en, ref_ready, clk_out_en, pde, wake_cause}), 32'd0);
        rst_n = 1'b1;
        repeat (SETTLE - 1) @(negedge clk);
        chk("R1 still held", 32'(slow_clk_en), 32'd0);
        @(negedge clk);
        chk("R1 released", 32'(slow_clk_en), 32'd1);

        // R2: power-down before full speed is ignored
        pde_set = 1'b1;
        @(negedge clk);
        pde_set = 1'b0;
        @(negedge clk);
        chk("R2 pde ignored", 32'({pde, ref_clk_en}), 32'd0);
        repeat (5) @(negedge clk);
        chk("R2 no auto switch", 32'(ref_clk_en), 32'd0);

        ref_switch_req = 1'b1;
        @(negedge clk);
        ref_switch_req = 1'b0;
        chk("R2 ref on", 32'(ref_clk_en), 32'd1);
        chk("R3 not ready", 32'(ref_ready), 32'd0);
        repeat (RESTART - 1) @(negedge clk);
        chk("R3 ready late", 32'({ref_ready, clk_out_en, ref_clk_en}), 32'b001);
        @(negedge clk);
        chk("R3 ready", 32'({ref_ready, clk_out_en}), 32'b11);
        chk("R1 slow stays", 32'(slow_clk_en), 32'd1);

        ref_switch_req = 1'b1;
        @(negedge clk);
        ref_switch_req = 1'b0;
        @(negedge clk);
        chk("R2 switch in run", 32'({ref_ready, ref_clk_en, pde}), 32'b110);

        // table of sleep/wake vectors: R5 R6 R7
        foreach (VECS[i]) begin
            exp_dur = 100000;
            if (VECS[i].tmr != 0) exp_dur = int'(VECS[i].tmr);
            if (VECS[i].mask[VECS[i].line] && (int'(VECS[i].dly) + 2 < exp_dur))
                exp_dur = int'(VECS[i].dly) + 2;
            exp_cause = '0;
            if (VECS[i].tmr != 0 && int'(VECS[i].tmr) == exp_dur) exp_cause[0] = 1'b1;
            if (VECS[i].mask[VECS[i].line] && int'(VECS[i].dly) + 2 == exp_dur)
                exp_cause[VECS[i].line + 1] = 1'b1;
            run_sleep(VECS[i].tmr, VECS[i].dly, VECS[i].line, VECS[i].mask, dur);
            chk($sformatf("R5 R6 vec%0d length", i), 32'(dur), 32'(exp_dur));
            chk($sformatf("R7 vec%0d cause", i), 32'(wake_cause), 32'(exp_cause));
            chk($sformatf("R7 vec%0d pde clear", i), 32'(pde), 32'd0);
            clear_cause(5'b11111);
            chk($sformatf("R8 vec%0d cleared", i), 32'(wake_cause), 32'd0);
        end

        // R5: zero load with no line activity stays asleep
        run_sleep(16'd0, 16'd300, 2'd1, 4'b0010, dur);
        chk("R5 zero load no timer wake", 32'(dur), 32'd302);
        chk("R7 line1 cause", 32'(wake_cause), 32'b00100);
        clear_cause(5'b11111);

        // R8: causes accumulate, partial clear
        run_sleep(16'd3, 16'd100, 2'd0, 4'b0000, dur);
        chk("R8 first cause", 32'(wake_cause), 32'b00001);
        run_sleep(16'd0, 16'd2, 2'd2, 4'b0100, dur);
        chk("R8 accumulate", 32'(wake_cause), 32'b01001);
        clear_cause(5'b00001);
        chk("R8 partial clear", 32'(wake_cause), 32'b01000);
        clear_cause(5'b01000);
        chk("R8 all clear", 32'(wake_cause), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule